// File: doc/BRIEF.md
# Static Memory Bank Timing Sequencer

This block paces accesses to external asynchronous memories that sit behind six chip selects. A requester presents one access at a time: a bank number, a direction, a burst marker and an address. The block drives the matching active-low chip select and the active-low output-enable or write-enable strobe. It reports completion with a single-cycle done pulse and holds its ready output low while an access is in progress. Each bank has its own timing, held in a small register file. The timing gives the number of read wait cycles, the number of idle cycles used to turn the data bus around, and a mode bit that marks the bank as a burst ROM.

An idle gap is placed between two accesses whenever the data direction flips, in either order. The length of the gap comes from the incoming access's bank. A bank in burst mode applies its read wait only to the opening beat of a run of burst reads. The later beats use the shortest possible strobe. A bank's timing is captured when its access is accepted, so register writes made during an access take effect from the next one.

Top module: `smc_bank_seq`

## Requirements
- R1: After reset every bank's idle field reads 0xF, every read-wait field reads 0x1F and every mode bit reads 0. Ready is high and all six chip selects are high (inactive).
- R2: Bank b's timing is held at byte address b*0x20. The idle count is at offset 0x0 in bits [3:0], the read wait at offset 0x4 in bits [4:0], and the burst-mode bit at offset 0x8 in bit 0 (1 = burst ROM). Bits above a field are dropped on write and read as zero, and any other address reads as zero.
- R3: A read to a bank in normal mode keeps that bank's chip select and the output enable low for W+1 consecutive cycles, where W is the bank's read-wait field.
- R4: A write keeps the chip select and the write enable low for exactly one cycle. The output and write enables are never low together.
- R5: When an access runs in the opposite direction to the previous access, I cycles with all chip selects high come between acceptance and the strobe, where I is the new bank's idle field. Two accesses in the same direction have no such gap, and neither does the first access after reset.
- R6: On a bank in burst mode, a read with the burst marker set, following a burst-marked read to that same bank, gets a one-cycle strobe. Any other read to that bank, including the first beat of a run, waits W cycles.
- R7: On a bank in normal mode the burst marker has no effect: every read waits W cycles.
- R8: Ready is low from the cycle after acceptance up to and including the final strobe cycle. Done is high only in the final strobe cycle.
- R9: An idle field of zero gives no gap, and a read-wait field of zero gives a one-cycle read strobe.
- R10: At most one chip select is low at a time, and it is the one for the accepted bank. The memory address output carries the accepted address from the cycle after acceptance until the next access is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| req_valid | input | 1 | Access request; taken in a cycle where req_ready is high |
| req_bank | input | 3 | Target bank 0..5 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | Marks the access as a beat of a burst |
| req_addr | input | 16 | Access address |
| req_ready | output | 1 | High when a new access can be taken |
| req_done | output | 1 | One-cycle pulse in the final strobe cycle |
| mem_cs_n | output | 6 | Active-low chip selects, one per bank |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_addr | output | 16 | Address of the current or last access |

## Verification
The bench builds the block with its default parameters: six banks, a 4-bit idle field and a 5-bit read-wait field. With these values the reset timings give the longest sequences, a 15-cycle gap followed by a 32-cycle strobe, and the bench runs them in full. Zero fields reach the one-cycle minimum, and a burst-mode bank can be compared against a normal bank under the same burst-marked traffic. Every cycle is compared against a behavioural model that builds a queue of expected pin states when each access is accepted.

// File: rtl/smc_pkg.sv
package smc_pkg;
    localparam int unsigned BANK_STRIDE = 32;
    localparam int unsigned OFS_IDLE    = 0;
    localparam int unsigned OFS_WAIT    = 4;
    localparam int unsigned OFS_MODE    = 8;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_TURN   = 2'd1,
        SEQ_STROBE = 2'd2
    } seq_state_e;
endpackage

// File: rtl/smc_timing_regs.sv
module smc_timing_regs #(
    parameter int NUM_BANKS = 6,
    parameter int IDLE_W    = 4,
    parameter int WAIT_W    = 5,
    parameter int RAW       = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [RAW-1:0]                      addr,
    input  logic [31:0]                         wdata,
    output logic [31:0]                         rdata,
    output logic [NUM_BANKS-1:0][IDLE_W-1:0]    idle_cfg,
    output logic [NUM_BANKS-1:0][WAIT_W-1:0]    wait_cfg,
    output logic [NUM_BANKS-1:0]                mode_cfg
);
    import smc_pkg::*;

    typedef struct packed {
        logic [NUM_BANKS-1:0][IDLE_W-1:0] idle;
        logic [NUM_BANKS-1:0][WAIT_W-1:0] wt;
        logic [NUM_BANKS-1:0]             mode;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [NUM_BANKS-1:0] hit_idle, hit_wait, hit_mode;
    logic unused_wdata;

    assign unused_wdata = ^wdata[31:1];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_dec
        assign hit_idle[b] = (addr == RAW'(b * BANK_STRIDE + OFS_IDLE));
        assign hit_wait[b] = (addr == RAW'(b * BANK_STRIDE + OFS_WAIT));
        assign hit_mode[b] = (addr == RAW'(b * BANK_STRIDE + OFS_MODE));
    end

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (hit_idle[b]) cfg_d.idle[b] = wdata[IDLE_W-1:0];
                if (hit_wait[b]) cfg_d.wt[b]   = wdata[WAIT_W-1:0];
                if (hit_mode[b]) cfg_d.mode[b] = wdata[0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (hit_idle[b]) rdata[IDLE_W-1:0] = cfg_q.idle[b];
            if (hit_wait[b]) rdata[WAIT_W-1:0] = cfg_q.wt[b];
            if (hit_mode[b]) rdata[0]          = cfg_q.mode[b];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.idle <= '1;
            cfg_q.wt   <= '1;
            cfg_q.mode <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign idle_cfg = cfg_q.idle;
    assign wait_cfg = cfg_q.wt;
    assign mode_cfg = cfg_q.mode;
endmodule

// File: rtl/smc_access_seq.sv
module smc_access_seq #(
    parameter int NUM_BANKS = 6,
    parameter int IDLE_W    = 4,
    parameter int WAIT_W    = 5,
    parameter int ADDR_W    = 16,
    parameter int BANK_W    = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             req_valid,
    input  logic [BANK_W-1:0]                req_bank,
    input  logic                             req_write,
    input  logic                             req_burst,
    input  logic [ADDR_W-1:0]                req_addr,
    input  logic [NUM_BANKS-1:0][IDLE_W-1:0] idle_cfg,
    input  logic [NUM_BANKS-1:0][WAIT_W-1:0] wait_cfg,
    input  logic [NUM_BANKS-1:0]             mode_cfg,
    output logic                             req_ready,
    output logic                             req_done,
    output logic [NUM_BANKS-1:0]             mem_cs_n,
    output logic                             mem_oe_n,
    output logic                             mem_we_n,
    output logic [ADDR_W-1:0]                mem_addr
);
    import smc_pkg::*;

    localparam int CNT_W = (IDLE_W > WAIT_W) ? IDLE_W : WAIT_W;

    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  wlen;
        logic [BANK_W-1:0] bank;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic              prev_ok;
        logic              prev_wr;
        logic              bopen;
        logic [BANK_W-1:0] bbank;
    } seq_t;

    seq_t s_d, s_q;

    logic              bank_ok;
    logic [CNT_W-1:0]  sel_idle, sel_wait, turn_len, wait_len;
    logic              sel_mode, dir_flip, burst_cont;

    assign bank_ok  = (int'(req_bank) < NUM_BANKS);
    assign sel_idle = bank_ok ? CNT_W'(idle_cfg[req_bank]) : '0;
    assign sel_wait = bank_ok ? CNT_W'(wait_cfg[req_bank]) : '0;
    assign sel_mode = bank_ok ? mode_cfg[req_bank] : 1'b0;

    assign dir_flip   = s_q.prev_ok && (s_q.prev_wr != req_write);
    assign burst_cont = s_q.bopen && (s_q.bbank == req_bank) && !req_write
                        && req_burst && sel_mode;
    assign turn_len   = dir_flip ? sel_idle : '0;
    assign wait_len   = (req_write || burst_cont) ? '0 : sel_wait;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            SEQ_IDLE: begin
                if (req_valid) begin
                    s_d.bank    = req_bank;
                    s_d.wr      = req_write;
                    s_d.addr    = req_addr;
                    s_d.prev_ok = 1'b1;
                    s_d.prev_wr = req_write;
                    s_d.bopen   = !req_write && req_burst && sel_mode;
                    s_d.bbank   = req_bank;
                    s_d.wlen    = wait_len;
                    if (turn_len != '0) begin
                        s_d.st  = SEQ_TURN;
                        s_d.cnt = turn_len - 1'b1;
                    end else begin
                        s_d.st  = SEQ_STROBE;
                        s_d.cnt = wait_len;
                    end
                end
            end
            SEQ_TURN: begin
                if (s_q.cnt == '0) begin
                    s_d.st  = SEQ_STROBE;
                    s_d.cnt = s_q.wlen;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            SEQ_STROBE: begin
                if (s_q.cnt == '0) s_d.st = SEQ_IDLE;
                else               s_d.cnt = s_q.cnt - 1'b1;
            end
            default: s_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cs
        assign mem_cs_n[b] = !((s_q.st == SEQ_STROBE) && (s_q.bank == BANK_W'(b)));
    end

    assign req_ready = (s_q.st == SEQ_IDLE);
    assign req_done  = (s_q.st == SEQ_STROBE) && (s_q.cnt == '0);
    assign mem_oe_n  = !((s_q.st == SEQ_STROBE) && !s_q.wr);
    assign mem_we_n  = !((s_q.st == SEQ_STROBE) && s_q.wr);
    assign mem_addr  = s_q.addr;
endmodule

// File: rtl/smc_bank_seq.sv
module smc_bank_seq #(
    parameter int NUM_BANKS = 6,
    parameter int IDLE_W    = 4,
    parameter int WAIT_W    = 5,
    parameter int ADDR_W    = 16,
    parameter int CFG_AW    = 8,
    parameter int BANK_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [CFG_AW-1:0]    cfg_addr,
    input  logic [31:0]          cfg_wdata,
    output logic [31:0]          cfg_rdata,
    input  logic                 req_valid,
    input  logic [BANK_W-1:0]    req_bank,
    input  logic                 req_write,
    input  logic                 req_burst,
    input  logic [ADDR_W-1:0]    req_addr,
    output logic                 req_ready,
    output logic                 req_done,
    output logic [NUM_BANKS-1:0] mem_cs_n,
    output logic                 mem_oe_n,
    output logic                 mem_we_n,
    output logic [ADDR_W-1:0]    mem_addr
);
    logic [NUM_BANKS-1:0][IDLE_W-1:0] idle_cfg;
    logic [NUM_BANKS-1:0][WAIT_W-1:0] wait_cfg;
    logic [NUM_BANKS-1:0]             mode_cfg;

    smc_timing_regs #(
        .NUM_BANKS(NUM_BANKS), .IDLE_W(IDLE_W), .WAIT_W(WAIT_W), .RAW(CFG_AW)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .addr(cfg_addr),
        .wdata(cfg_wdata), .rdata(cfg_rdata),
        .idle_cfg(idle_cfg), .wait_cfg(wait_cfg), .mode_cfg(mode_cfg)
    );

    smc_access_seq #(
        .NUM_BANKS(NUM_BANKS), .IDLE_W(IDLE_W), .WAIT_W(WAIT_W),
        .ADDR_W(ADDR_W), .BANK_W(BANK_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
        .req_write(req_write), .req_burst(req_burst), .req_addr(req_addr),
        .idle_cfg(idle_cfg), .wait_cfg(wait_cfg), .mode_cfg(mode_cfg),
        .req_ready(req_ready), .req_done(req_done), .mem_cs_n(mem_cs_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr)
    );
endmodule

// File: rtl/smc_bank_seq_chk.sv
module smc_bank_seq_chk #(
    parameter int NUM_BANKS = 6,
    parameter int ADDR_W    = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_ready,
    input logic                 req_done,
    input logic [NUM_BANKS-1:0] mem_cs_n,
    input logic                 mem_oe_n,
    input logic                 mem_we_n,
    input logic [ADDR_W-1:0]    mem_addr
);
    // R10: never two banks selected at once
    p_cs_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_cs_n));

    // R4: output and write enables are mutually exclusive
    p_oe_we_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    // R4: write strobe lasts one cycle
    p_we_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |=> mem_we_n);

    // R8: done is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |=> !req_done);

    // R8: done only while a chip select is active, never with ready
    p_done_in_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |-> (!(&mem_cs_n) && !req_ready));

    // R8: ready high means the bus is released
    p_ready_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> ((&mem_cs_n) && mem_oe_n && mem_we_n));

    // R10: a strobe only with a chip select
    p_strobe_has_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n || !mem_we_n) |-> !(&mem_cs_n));

    // R10: address and select held through a multi-cycle strobe
    p_addr_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&mem_cs_n) && !req_done) |=> ($stable(mem_addr) && $stable(mem_cs_n)));
endmodule

bind smc_bank_seq smc_bank_seq_chk #(
    .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .req_done(req_done),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr)
);

// File: tb/tb_smc_bank_seq.sv
`timescale 1ns/1ps
module tb_smc_bank_seq;
    localparam int NB = 6;
    typedef logic [25:0] word_t; // {ready, done, cs_n[5:0], oe_n, we_n, addr[15:0]}

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [2:0]  req_bank = '0;
    logic        req_write = 1'b0;
    logic        req_burst = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_ready, req_done, mem_oe_n, mem_we_n;
    logic [5:0]  mem_cs_n;
    logic [15:0] mem_addr;

    always #10 clk = ~clk; // 50 MHz

    smc_bank_seq dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
        .req_bank(req_bank), .req_write(req_write), .req_burst(req_burst),
        .req_addr(req_addr), .req_ready(req_ready), .req_done(req_done),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_addr(mem_addr)
    );

    int    n_checks = 0;
    int    n_fails  = 0;
    int    cycles   = 0;
    bit    ended    = 0;
    string cur_req  = "R1";

    // behavioural model state
    int          m_idle [NB];
    int          m_wait [NB];
    bit          m_mode [NB];
    bit          m_prev_ok, m_prev_wr, m_bopen;
    int          m_bbank;
    logic [15:0] m_last_addr;
    word_t       exp_q[$];

    task automatic model_reset();
        for (int b = 0; b < NB; b++) begin
            m_idle[b] = 15; m_wait[b] = 31; m_mode[b] = 0;
        end
        m_prev_ok = 0; m_prev_wr = 0; m_bopen = 0; m_bbank = 0;
        m_last_addr = '0;
        exp_q.delete();
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            if (req_valid && exp_q.size() == 0) begin
                int  b, t, w;
                bit  cont;
                b    = int'(req_bank);
                t    = (m_prev_ok && (m_prev_wr != req_write)) ? m_idle[b] : 0;
                cont = m_bopen && (m_bbank == b) && !req_write && req_burst && m_mode[b];
                w    = (req_write || cont) ? 0 : m_wait[b];
                for (int k = 0; k < t; k++)
                    exp_q.push_back({1'b0, 1'b0, 6'h3f, 1'b1, 1'b1, req_addr});
                for (int k = 0; k <= w; k++)
                    exp_q.push_back({1'b0, (k == w), ~(6'b1 << b),
                                     req_write, !req_write, req_addr});
                m_prev_ok   = 1; m_prev_wr = req_write;
                m_bopen     = !req_write && req_burst && m_mode[b];
                m_bbank     = b;
                m_last_addr = req_addr;
            end
            if (cfg_wr && (cfg_addr / 32) < NB) begin
                case (cfg_addr % 32)
                    0: m_idle[cfg_addr / 32] = int'(cfg_wdata[3:0]);
                    4: m_wait[cfg_addr / 32] = int'(cfg_wdata[4:0]);
                    8: m_mode[cfg_addr / 32] = cfg_wdata[0];
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !ended) begin
            word_t e, g;
            e = (exp_q.size() != 0) ? exp_q[0]
                                    : {1'b1, 1'b0, 6'h3f, 1'b1, 1'b1, m_last_addr};
            g = {req_ready, req_done, mem_cs_n, mem_oe_n, mem_we_n, mem_addr};
            n_checks++;
            if (g !== e) begin
                n_fails++;
                $display("FAIL %s pins at cycle %0d: got %h expected %h", cur_req, cycles, g, e);
            end
            if (exp_q.size() != 0) void'(exp_q.pop_front());
        end
    end

    task automatic cfg_write(input int a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 8'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_check(input string rq, input int a, input logic [31:0] e);
        @(negedge clk);
        cfg_addr = 8'(a);
        #1;
        n_checks++;
        if (cfg_rdata !== e) begin
            n_fails++;
            $display("FAIL %s reg 0x%0h: got %h expected %h", rq, a, cfg_rdata, e);
        end
    endtask

    task automatic access(input int b, input bit wr, input bit bu, input logic [15:0] a);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_bank = 3'(b); req_write = wr; req_burst = bu; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !ended) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values of every bank
        cur_req = "R1";
        for (int b = 0; b < NB; b++) begin
            cfg_check("R1", b * 32 + 0, 32'hF);
            cfg_check("R1", b * 32 + 4, 32'h1F);
            cfg_check("R1", b * 32 + 8, 32'h0);
        end

        // R2: field placement, dropped upper bits, unmapped reads
        cur_req = "R2";
        cfg_write(2 * 32 + 0, 32'hFFFF_FFF3);
        cfg_write(2 * 32 + 4, 32'hABCD_0004);
        cfg_write(3 * 32 + 8, 32'hFFFF_FFFF);
        cfg_check("R2", 2 * 32 + 0, 32'h3);
        cfg_check("R2", 2 * 32 + 4, 32'h4);
        cfg_check("R2", 3 * 32 + 8, 32'h1);
        cfg_check("R2", 2 * 32 + 12, 32'h0);
        cfg_check("R2", 6 * 32 + 0, 32'h0);
        cfg_check("R2", 1 * 32 + 0, 32'hF);

        // R3: first read after reset, no gap, 4 waits
        cur_req = "R3";
        access(2, 0, 0, 16'h1234);
        drain();

        // R4 and R5: direction flip to write on bank 2 (idle 3), then a same-direction write
        cur_req = "R4";
        access(2, 1, 0, 16'h2000);
        access(2, 1, 0, 16'h2001);
        drain();

        // R5: flip back to read on bank 0 with reset timing (15 idle, 31 wait)
        cur_req = "R5";
        access(0, 0, 0, 16'h0ABC);
        drain();

        // R9: zero fields on bank 1
        cur_req = "R9";
        cfg_write(1 * 32 + 0, 0);
        cfg_write(1 * 32 + 4, 0);
        access(1, 1, 0, 16'h1111);
        access(1, 0, 0, 16'h1112);
        access(1, 0, 0, 16'h1113);
        drain();

        // R6: burst reads on bank 3 (mode set above), wait 6, idle 2
        cur_req = "R6";
        cfg_write(3 * 32 + 0, 2);
        cfg_write(3 * 32 + 4, 6);
        access(3, 0, 1, 16'h3000);
        access(3, 0, 1, 16'h3001);
        access(3, 0, 1, 16'h3002);
        access(3, 0, 0, 16'h3003);
        access(3, 0, 1, 16'h3004);
        access(2, 0, 1, 16'h3005);
        access(3, 0, 1, 16'h3006);
        drain();

        // R7: burst marker on a normal-mode bank
        cur_req = "R7";
        access(2, 0, 1, 16'h4000);
        access(2, 0, 1, 16'h4001);
        drain();

        // R8 and R10: mixed traffic across all banks
        cur_req = "R8";
        cfg_write(0 * 32 + 0, 1);
        cfg_write(0 * 32 + 4, 2);
        cfg_write(4 * 32 + 4, 3);
        cfg_write(5 * 32 + 0, 4);
        cfg_write(5 * 32 + 4, 1);
        for (int i = 0; i < 30; i++) begin
            cur_req = (i % 2 == 0) ? "R8" : "R10";
            access(i % NB, ((i * 7) % 3) == 0, i[0], 16'(16'h5000 + i));
        end
        drain();

        finish_run();
    end
endmodule